// File: doc/BRIEF.md
# Four-dimensional scanout address generator

The block turns a raster walk over an output view into read addresses for a light-field framebuffer. The framebuffer is a four-dimensional array indexed by (s, t, u, v). A view is a plane through that array, so every one of the four indices is an affine function of the output pixel position (x, y). Four copies of one incremental fixed-point evaluator follow these functions. Each copy adds its per-pixel step along a line and its per-line step at every line end. The four results are clamped to the array bounds and packed into one linear word address.

A host loads the base value and the two step values of each evaluator through a small write port. Writes go to staging registers and only reach the evaluators at a frame boundary, so a view never changes halfway through a frame. The pixel clock enable advances the raster by one pixel. The address, an in-range flag, a pixel strobe and a frame-start strobe come out one clock later. A separate combinational path splits the 32-bit word returned by memory into 5/6/5 colour fields and a 16-bit depth.

Top module: `lfv_scan_addr`

## Requirements
- R1: While reset is held, `fb_addr` is zero and `pix_stb`, `pix_ok` and `frame_start` are low.
- R2: Each clock with `pix_en` high accepts one pixel. x runs from 0 to H_PIX-1 and then y steps, y runs from 0 to V_PIX-1, and after the last pixel the walk returns to (0,0). Results for an accepted pixel appear on the outputs at the next clock edge, and `pix_stb` is high exactly in those cycles. While `pix_en` is low the raster position holds and `fb_addr` holds.
- R3: `frame_start` is high together with `pix_stb` for pixel (0,0) only.
- R4: For coordinate k, the index is floor((B_k + x*X_k + y*Y_k) / 256). B, X and Y are CW-bit two's-complement values with 8 fraction bits.
- R5: An index below 0 is clamped to 0 and one at or above its dimension is clamped to dimension-1. `pix_ok` is low when any of the four indices was clamped, and high otherwise for an accepted pixel.
- R6: `fb_addr` = ((s*DIM_T + t)*DIM_U + u)*DIM_V + v, using the clamped indices.
- R7: A write with `cfg_we` high selects the coordinate with `cfg_sel[3:2]` (0=s, 1=t, 2=u, 3=v) and the value with `cfg_sel[1:0]` (0=base B, 1=x step X, 2=y step Y). A write with `cfg_sel[1:0]`=3 has no effect.
- R8: Writes are staged. The staged values become active on a clock edge that accepts the last pixel of a frame, or on any edge where the raster sits at (0,0) with `pix_en` low. A write on that same edge is staged for the following boundary.
- R9: `red`=`rd_word[31:27]`, `grn`=`rd_word[26:21]`, `blu`=`rd_word[20:16]` and `depth`=`rd_word[15:0]`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Accept one raster pixel this cycle |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 4 | Coordinate [3:2] and value [1:0] select |
| cfg_data | input | CW | Signed coefficient, 8 fraction bits |
| fb_addr | output | ADDR_W | Linear framebuffer word address |
| pix_stb | output | 1 | An address for an accepted pixel is present |
| pix_ok | output | 1 | All four indices were inside the array |
| frame_start | output | 1 | Present pixel is (0,0) |
| rd_word | input | 32 | Word returned from framebuffer memory |
| red | output | 5 | Red field |
| grn | output | 6 | Green field |
| blu | output | 5 | Blue field |
| depth | output | 16 | Depth field |

## Verification
Address, in-range flag and both strobes are due on the clock edge after the cycle that accepts a pixel. The colour fields follow the returned word with no clock delay. A staged coefficient only shows in addresses for pixels accepted after the next frame boundary. The bench model advances at each rising edge from the inputs set up half a cycle earlier and predicts the registered outputs. Every falling edge then compares those predictions with the ports. The unpack path is compared a short delay after the word changes. Coefficient writes are placed mid-frame, in idle cycles at the origin, and with the unused select code, and the enable is gapped, so each boundary rule shows up in the address stream.

// File: rtl/lfv_pkg.sv
package lfv_pkg;

   typedef enum logic [1:0] {
      CF_BASE  = 2'd0,
      CF_XSTEP = 2'd1,
      CF_YSTEP = 2'd2,
      CF_NONE  = 2'd3
   } coef_sel_e;

   localparam int NUM_CRD = 4;
   localparam int FRAC_BITS = 8;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

   function automatic int max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/lfv_raster.sv
module lfv_raster #(
   parameter int H_PIX = 640,
   parameter int V_PIX = 480
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic at_origin,
   output logic line_end,
   output logic last_pix
);
   localparam int XW = (H_PIX > 1) ? $clog2(H_PIX) : 1;
   localparam int YW = (V_PIX > 1) ? $clog2(V_PIX) : 1;
   localparam logic [XW-1:0] X_LAST = XW'(H_PIX - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(V_PIX - 1);

   if (H_PIX < 2) begin : g_bad_h
      $error("lfv_raster: H_PIX must be at least 2");
   end
   if (V_PIX < 2) begin : g_bad_v
      $error("lfv_raster: V_PIX must be at least 2");
   end

   logic [XW-1:0] xq;
   logic [YW-1:0] yq;

   assign line_end  = (xq == X_LAST);
   assign last_pix  = line_end && (yq == Y_LAST);
   assign at_origin = (xq == '0) && (yq == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xq <= '0;
         yq <= '0;
      end else if (en) begin
         if (line_end) begin
            xq <= '0;
            yq <= last_pix ? '0 : yq + 1'b1;
         end else begin
            xq <= xq + 1'b1;
         end
      end
   end

   AST_X_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      xq <= X_LAST);   // R2
   AST_Y_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      yq <= Y_LAST);   // R2
   AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && line_end) |=> (xq == '0));   // R2
   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && last_pix) |=> at_origin);   // R2
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(xq) && $stable(yq)));   // R2

endmodule

// File: rtl/lfv_lin_eval.sv
module lfv_lin_eval #(
   parameter int CW    = 20,
   parameter int FRAC  = 8,
   parameter int GUARD = 12,
   parameter int DIM   = 256,
   parameter int CRD_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             commit,
   input  logic             line_end,
   input  logic             wr_base,
   input  logic             wr_xstep,
   input  logic             wr_ystep,
   input  logic [CW-1:0]    wdata,
   output logic [CRD_W-1:0] crd,
   output logic             in_range
);
   localparam int ACC_W = CW + GUARD;
   localparam int IW    = ACC_W - FRAC;
   localparam logic signed [IW-1:0]  LIM = IW'(DIM);
   localparam logic [CRD_W-1:0]      TOP = CRD_W'(DIM - 1);

   if (FRAC >= CW) begin : g_bad_frac
      $error("lfv_lin_eval: FRAC must be below CW");
   end
   if ((1 << CRD_W) < DIM) begin : g_bad_crd
      $error("lfv_lin_eval: CRD_W too narrow for DIM");
   end
   if (IW <= CRD_W) begin : g_bad_iw
      $error("lfv_lin_eval: integer part narrower than coordinate");
   end

   // staging and active copies of the three coefficients
   logic [CW-1:0] stg_b, stg_x, stg_y;
   logic [CW-1:0] act_x, act_y;

   logic signed [ACC_W-1:0] acc, lstart;
   logic signed [ACC_W-1:0] x_ext, y_ext, b_ext;
   logic signed [IW-1:0]    ipart;
   logic under, over;

   assign b_ext = {{GUARD{stg_b[CW-1]}}, stg_b};
   assign x_ext = {{GUARD{act_x[CW-1]}}, act_x};
   assign y_ext = {{GUARD{act_y[CW-1]}}, act_y};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_b <= '0;
         stg_x <= '0;
         stg_y <= '0;
      end else begin
         if (wr_base)  stg_b <= wdata;
         if (wr_xstep) stg_x <= wdata;
         if (wr_ystep) stg_y <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_x  <= '0;
         act_y  <= '0;
         acc    <= '0;
         lstart <= '0;
      end else if (commit) begin
         act_x  <= stg_x;
         act_y  <= stg_y;
         acc    <= b_ext;
         lstart <= b_ext;
      end else if (en) begin
         if (line_end) begin
            acc    <= lstart + y_ext;
            lstart <= lstart + y_ext;
         end else begin
            acc <= acc + x_ext;
         end
      end
   end

   assign ipart    = acc[ACC_W-1:FRAC];
   assign under    = ipart[IW-1];
   assign over     = !under && (ipart >= LIM);
   assign in_range = !under && !over;
   assign crd      = under ? '0 : (over ? TOP : ipart[CRD_W-1:0]);

   AST_CRD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      crd <= TOP);   // R5
   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !commit) |=> $stable(acc));   // R2
   AST_ACT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(act_x) && $stable(act_y)));   // R8

endmodule

// File: rtl/lfv_scale.sv
module lfv_scale #(
   parameter int DIM = 256,
   parameter int W   = 22
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   import lfv_pkg::*;

   if (DIM < 2) begin : g_bad_dim
      $error("lfv_scale: DIM must be at least 2");
   end

   if (is_pow2(DIM)) begin : g_shift
      localparam int SH = $clog2(DIM);
      assign y = a << SH;
   end else begin : g_mult
      localparam logic [W-1:0] K = W'(DIM);
      assign y = a * K;
   end

endmodule

// File: rtl/lfv_addr.sv
module lfv_addr #(
   parameter int DIM_T  = 8,
   parameter int DIM_U  = 256,
   parameter int DIM_V  = 256,
   parameter int CRD_W  = 8,
   parameter int ADDR_W = 22
) (
   input  logic [CRD_W-1:0]  s,
   input  logic [CRD_W-1:0]  t,
   input  logic [CRD_W-1:0]  u,
   input  logic [CRD_W-1:0]  v,
   output logic [ADDR_W-1:0] addr
);
   if (CRD_W > ADDR_W) begin : g_bad_w
      $error("lfv_addr: coordinate wider than address");
   end

   logic [ADDR_W-1:0] s_sc, p1, p1_sc, p2, p2_sc;

   lfv_scale #(.DIM(DIM_T), .W(ADDR_W)) u_sc_t (.a(ADDR_W'(s)), .y(s_sc));
   assign p1 = s_sc + ADDR_W'(t);

   lfv_scale #(.DIM(DIM_U), .W(ADDR_W)) u_sc_u (.a(p1), .y(p1_sc));
   assign p2 = p1_sc + ADDR_W'(u);

   lfv_scale #(.DIM(DIM_V), .W(ADDR_W)) u_sc_v (.a(p2), .y(p2_sc));
   assign addr = p2_sc + ADDR_W'(v);

endmodule

// File: rtl/lfv_unpack.sv
module lfv_unpack (
   input  logic [31:0] word,
   output logic [4:0]  red,
   output logic [5:0]  grn,
   output logic [4:0]  blu,
   output logic [15:0] depth
);
   logic [15:0] colour;

   assign colour = word[31:16];
   assign red    = colour[15:11];
   assign grn    = colour[10:5];
   assign blu    = colour[4:0];
   assign depth  = word[15:0];

endmodule

// File: rtl/lfv_scan_addr.sv
module lfv_scan_addr #(
   parameter int H_PIX  = 640,
   parameter int V_PIX  = 480,
   parameter int DIM_S  = 8,
   parameter int DIM_T  = 8,
   parameter int DIM_U  = 256,
   parameter int DIM_V  = 256,
   parameter int CW     = 20,
   parameter int GUARD  = 12,
   parameter int ADDR_W = $clog2(DIM_S * DIM_T * DIM_U * DIM_V)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pix_en,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_sel,
   input  logic [CW-1:0]     cfg_data,
   output logic [ADDR_W-1:0] fb_addr,
   output logic              pix_stb,
   output logic              pix_ok,
   output logic              frame_start,
   input  logic [31:0]       rd_word,
   output logic [4:0]        red,
   output logic [5:0]        grn,
   output logic [4:0]        blu,
   output logic [15:0]       depth
);
   import lfv_pkg::*;

   localparam int DMAX  = max4(DIM_S, DIM_T, DIM_U, DIM_V);
   localparam int CRD_W = $clog2(DMAX);
   localparam longint TOTAL = longint'(DIM_S) * DIM_T * DIM_U * DIM_V;

   if ((longint'(1) << ADDR_W) < TOTAL) begin : g_bad_addr
      $error("lfv_scan_addr: ADDR_W too narrow for the array");
   end
   if (GUARD < $clog2(H_PIX + V_PIX) + 1) begin : g_bad_guard
      $error("lfv_scan_addr: GUARD too small for the raster");
   end

   function automatic int dim_of(input int k);
      case (k)
         0:       return DIM_S;
         1:       return DIM_T;
         2:       return DIM_U;
         default: return DIM_V;
      endcase
   endfunction

   logic at_origin, line_end, last_pix, commit;
   logic [CRD_W-1:0]      crd [NUM_CRD];
   logic [NUM_CRD-1:0]    inr;
   logic [ADDR_W-1:0]     addr_d;

   lfv_raster #(.H_PIX(H_PIX), .V_PIX(V_PIX)) u_raster (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (pix_en),
      .at_origin(at_origin),
      .line_end (line_end),
      .last_pix (last_pix)
   );

   // staged coefficients go live at the frame boundary
   assign commit = (at_origin && !pix_en) || (pix_en && last_pix);

   for (genvar g = 0; g < NUM_CRD; g++) begin : g_eval
      logic hit;
      assign hit = cfg_we && (cfg_sel[3:2] == 2'(g));
      lfv_lin_eval #(
         .CW   (CW),
         .FRAC (FRAC_BITS),
         .GUARD(GUARD),
         .DIM  (dim_of(g)),
         .CRD_W(CRD_W)
      ) u_eval (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (pix_en),
         .commit  (commit),
         .line_end(line_end),
         .wr_base (hit && (cfg_sel[1:0] == CF_BASE)),
         .wr_xstep(hit && (cfg_sel[1:0] == CF_XSTEP)),
         .wr_ystep(hit && (cfg_sel[1:0] == CF_YSTEP)),
         .wdata   (cfg_data),
         .crd     (crd[g]),
         .in_range(inr[g])
      );
   end

   lfv_addr #(
      .DIM_T (DIM_T),
      .DIM_U (DIM_U),
      .DIM_V (DIM_V),
      .CRD_W (CRD_W),
      .ADDR_W(ADDR_W)
   ) u_addr (
      .s   (crd[0]),
      .t   (crd[1]),
      .u   (crd[2]),
      .v   (crd[3]),
      .addr(addr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fb_addr     <= '0;
         pix_stb     <= 1'b0;
         pix_ok      <= 1'b0;
         frame_start <= 1'b0;
      end else begin
         pix_stb     <= pix_en;
         pix_ok      <= pix_en && (&inr);
         frame_start <= pix_en && at_origin;
         if (pix_en) fb_addr <= addr_d;
      end
   end

   lfv_unpack u_unpack (
      .word (rd_word),
      .red  (red),
      .grn  (grn),
      .blu  (blu),
      .depth(depth)
   );

   AST_FS_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> pix_stb);   // R3
   AST_OK_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
      pix_ok |-> pix_stb);   // R5
   AST_ADDR_IN_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      pix_stb |-> (longint'(fb_addr) < TOTAL));   // R6
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable(fb_addr));   // R2
   AST_FS_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && last_pix) |=> !frame_start);   // R3

endmodule

// File: tb/lfv_scan_addr_test.sv
module lfv_scan_addr_test;
   localparam int CLK_PERIOD = 10;
   localparam int H = 20, V = 6;
   localparam int DS = 8, DT = 6, DU = 16, DV = 16;
   localparam int CW = 20;
   localparam int AW = $clog2(DS * DT * DU * DV);

   logic clk = 0, rst_n = 0, pix_en = 0, cfg_we = 0;
   logic [3:0] cfg_sel = 0;
   logic [CW-1:0] cfg_data = 0;
   logic [31:0] rd_word = 0;
   logic [AW-1:0] fb_addr;
   logic pix_stb, pix_ok, frame_start;
   logic [4:0] red, blu;
   logic [5:0] grn;
   logic [15:0] depth;

   int n_chk = 0, n_fail = 0;
   string phase = "R1";

   lfv_scan_addr #(.H_PIX(H), .V_PIX(V), .DIM_S(DS), .DIM_T(DT), .DIM_U(DU),
      .DIM_V(DV), .CW(CW)) uut (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .fb_addr(fb_addr),
      .pix_stb(pix_stb), .pix_ok(pix_ok), .frame_start(frame_start),
      .rd_word(rd_word), .red(red), .grn(grn), .blu(blu), .depth(depth));

   always #(CLK_PERIOD / 2) clk = ~clk;

   // behavioural reference model
   int dims [4] = '{DS, DT, DU, DV};
   int stg [4][3];
   int act [4][3];
   int mx = 0, my = 0;
   int e_addr = 0, e_stb = 0, e_ok = 0, e_fs = 0;

   function automatic int sx(input logic [CW-1:0] d);
      return int'($signed(d));
   endfunction

   initial begin
      foreach (stg[k, j]) begin
         stg[k][j] = 0;
         act[k][j] = 0;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         mx = 0; my = 0; e_addr = 0; e_stb = 0; e_ok = 0; e_fs = 0;
         foreach (stg[k, j]) begin
            stg[k][j] = 0;
            act[k][j] = 0;
         end
      end else begin
         bit go_live;
         go_live = (mx == 0 && my == 0 && !pix_en) ||
                   (pix_en && mx == H - 1 && my == V - 1);
         if (pix_en) begin
            int c [4];
            int ok;
            ok = 1;
            for (int k = 0; k < 4; k++) begin
               int q;
               q = (act[k][0] + mx * act[k][1] + my * act[k][2]) >>> 8;
               if (q < 0) begin q = 0; ok = 0; end
               else if (q >= dims[k]) begin q = dims[k] - 1; ok = 0; end
               c[k] = q;
            end
            e_addr = ((c[0] * DT + c[1]) * DU + c[2]) * DV + c[3];
            e_stb = 1; e_ok = ok; e_fs = (mx == 0 && my == 0);
            if (mx == H - 1) begin
               mx = 0;
               my = (my == V - 1) ? 0 : my + 1;
            end else mx = mx + 1;
         end else begin
            e_stb = 0; e_ok = 0; e_fs = 0;
         end
         if (go_live) foreach (act[k, j]) act[k][j] = stg[k][j];
         if (cfg_we && cfg_sel[1:0] != 2'd3)
            stg[cfg_sel[3:2]][cfg_sel[1:0]] = sx(cfg_data);
      end
   end

   task automatic check(input string req, input int act_v, input int exp_v);
      n_chk++;
      if (act_v != exp_v) begin
         n_fail++;
         $display("FAIL %s (phase %s) t=%0t: actual %0d expected %0d",
                  req, phase, $time, act_v, exp_v);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check("R6 address", int'(fb_addr), e_addr);
         check("R2 pix_stb", int'(pix_stb), e_stb);
         check("R5 pix_ok", int'(pix_ok), e_ok);
         check("R3 frame_start", int'(frame_start), e_fs);
      end
   end

   task automatic tick(input bit en);
      @(negedge clk);
      pix_en = en;
      cfg_we = 0;
   endtask

   task automatic wr(input int crd, input int sel, input int val, input bit en);
      @(negedge clk);
      pix_en = en;
      cfg_we = 1;
      cfg_sel = 4'((crd << 2) | sel);
      cfg_data = CW'(val);
   endtask

   task automatic unpack_chk(input logic [31:0] w);
      rd_word = w;
      #1;
      check("R9 red", int'(red), int'(w[31:27]));
      check("R9 grn", int'(grn), int'(w[26:21]));
      check("R9 blu", int'(blu), int'(w[20:16]));
      check("R9 depth", int'(depth), int'(w[15:0]));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 fb_addr", int'(fb_addr), 0);
      check("R1 pix_stb", int'(pix_stb), 0);
      check("R1 pix_ok", int'(pix_ok), 0);
      check("R1 frame_start", int'(frame_start), 0);
      phase = "R9";
      unpack_chk(32'hF800_1234);
      unpack_chk(32'h07E0_FFFF);
      unpack_chk(32'hA5C3_0001);
      @(negedge clk);
      rst_n = 1;

      // view A, loaded at the origin while idle (R7, R8)
      phase = "R7";
      wr(0, 0, 2 * 256, 0); wr(0, 1, 0, 0);    wr(0, 2, 'h60, 0);
      wr(1, 0, 384, 0);     wr(1, 1, 'h50, 0); wr(1, 2, 0, 0);
      wr(2, 0, 0, 0);       wr(2, 1, 256, 0);  wr(2, 2, 0, 0);
      wr(3, 0, 15 * 256 + 200, 0); wr(3, 1, 0, 0); wr(3, 2, -256, 0);
      tick(0); tick(0);

      // full frame A, view B staged mid-frame (R4, R5, R8)
      phase = "R4";
      for (int i = 0; i < 50; i++) tick(1);
      phase = "R8";
      wr(2, 0, -3 * 256, 1); wr(2, 1, 200, 1); wr(2, 2, 64, 1);
      wr(0, 0, 7 * 256, 1);  wr(0, 2, 100, 1); wr(3, 1, -30, 1);
      for (int i = 0; i < H * V; i++) tick(1);

      // frame B with gaps in the enable (R2)
      phase = "R2";
      for (int i = 0; i < 3 * H * V; i++) tick((i % 3) != 1);
      while (!(uut.pix_stb === 1'b0 && 0)) begin
         break;
      end

      // unused select code must leave the view alone (R7)
      phase = "R7";
      wr(1, 3, 5 * 256, 0);
      wr(1, 0, 256, 1);
      for (int i = 0; i < 2 * H * V; i++) tick((i % 5) != 0);
      tick(0);
      for (int i = 0; i < 8; i++) tick(0);
      tick(0);
      repeat (2) @(negedge clk);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule